// File: doc/BRIEF.md
# Disk Motor Control with Spin-Down Hold

This block is the motor-control part of a floppy disk interface controller. The host sets or clears a motor latch with one-cycle strobes. Setting the latch switches the drive motor on at once. Clearing it does not stop the drive straight away. The delayed motor-enable output stays high for a hold-off period, so the drive keeps spinning and stays readable. Back-to-back accesses therefore avoid the cost of stopping and restarting the spindle. The live latch is brought out on its own pin, next to the delayed motor-enable, so that logic using the block can tell a host request apart from a drive that is only spinning down.

The hold-off is counted in pulses of a timer tick input. `HOLD_TICKS` defaults to one million, which gives about one second with a 1 MHz tick. A 4-bit mode register holds the transfer timing selection: asynchronous write handshake or synchronous read sampling. It also holds a hold bypass bit and two auxiliary bits. The register accepts writes only while the drive is completely stopped. A write that arrives while the motor-enable output is high is dropped silently.

Top module: `dm_motor_ctl`

## Requirements
- R1: A `latch_set` strobe makes `latch_live` and `motor_en` high from the next cycle on. When `latch_set` and `latch_clr` arrive together, the set wins.
- R2: A `latch_clr` strobe while the latch is set drives `latch_live` low on the next cycle, and `motor_en` stays high without a gap. A `latch_clr` while the latch is already clear has no effect and does not restart the hold-off.
- R3: After a clear, `motor_en` goes low on the cycle after the `HOLD_TICKS`-th `tick` pulse. Only pulses in the cycles after the clearing cycle are counted. A `tick` in the clearing cycle itself is not counted.
- R4: A `latch_set` during the hold-off cancels the hold-off, and `motor_en` stays high without interruption.
- R5: A `mode_wr` while `motor_en` is high is ignored, and `mode_o` keeps its previous value.
- R6: A `mode_wr` while `motor_en` is low loads `mode_wdata` into `mode_o`, visible on the next cycle.
- R7: After reset, `latch_live` is 0, `motor_en` is 0, no hold-off is running and `mode_o` is 0.
- R8: Mode bit 1 is the hold bypass. When it is 1, clearing the set latch drops `motor_en` on the next cycle, with no hold-off.
- R9: Mode bit 0 selects the transfer timing: 1 means asynchronous write handshake and 0 means synchronous read sampling. It is presented on `async_xfer`. Bits 3:2 are auxiliary bits that are only stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| latch_set | input | 1 | One-cycle strobe that sets the motor latch |
| latch_clr | input | 1 | One-cycle strobe that clears the motor latch |
| tick | input | 1 | Time-base pulse used to count the hold-off |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode write data (bit0 async transfer, bit1 hold bypass, bits 3:2 auxiliary) |
| motor_en | output | 1 | Delayed motor enable; the drive is readable while it is high |
| latch_live | output | 1 | Live state of the motor latch |
| mode_o | output | 4 | Current mode register contents |
| async_xfer | output | 1 | 1 selects asynchronous write timing, 0 selects synchronous read timing |

## Verification
The assertions assume that the strobes are sampled only on clock edges. They also assume that `tick` is a single-cycle pulse at most once per clock, and that reset is held for at least one edge before any strobe is used. The bench drives every input just after the falling edge, so each one is stable across the next rising edge. It also keeps reset asserted for several cycles before the first command. The random phase still covers simultaneous set and clear, ticks in the clearing cycle, and mode writes at every stage of the spin-down.

// File: rtl/dm_pkg.sv
package dm_pkg;

    localparam int MODE_W = 4;

    typedef struct packed {
        logic [1:0] aux;
        logic       no_hold;
        logic       async_xfer;
    } dm_mode_t;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_SET  = 2'd1,
        CMD_CLR  = 2'd2
    } dm_cmd_e;

    function automatic dm_cmd_e decode_cmd(input logic set_s, input logic clr_s);
        if (set_s)      return CMD_SET;
        else if (clr_s) return CMD_CLR;
        else            return CMD_NONE;
    endfunction

    function automatic dm_mode_t mode_from_bits(input logic [MODE_W-1:0] b);
        return dm_mode_t'(b);
    endfunction

endpackage

// File: rtl/dm_spin_timer.sv
module dm_spin_timer
    import dm_pkg::*;
#(
    parameter int HOLD_TICKS = 1000000
) (
    input  logic    clk,
    input  logic    rst,
    input  dm_cmd_e cmd,
    input  logic    tick,
    input  logic    no_hold,
    output logic    latch_q,
    output logic    motor_on
);
    localparam int CNT_W = $clog2(HOLD_TICKS + 1);

    logic             hold_act;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q  <= 1'b0;
            hold_act <= 1'b0;
            cnt      <= '0;
        end else begin
            case (cmd)
                CMD_SET: begin
                    latch_q  <= 1'b1;
                    hold_act <= 1'b0;
                    cnt      <= '0;
                end
                CMD_CLR: begin
                    if (latch_q) begin
                        latch_q  <= 1'b0;
                        hold_act <= !no_hold;
                        cnt      <= '0;
                    end else if (hold_act && tick) begin
                        if (cnt == CNT_W'(HOLD_TICKS - 1)) begin
                            hold_act <= 1'b0;
                            cnt      <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (hold_act && tick) begin
                        if (cnt == CNT_W'(HOLD_TICKS - 1)) begin
                            hold_act <= 1'b0;
                            cnt      <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign motor_on = latch_q | hold_act;

    AST_SET_STARTS_MOTOR: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_SET) |=> (latch_q && motor_on)) else $error("set failed"); // R1

    AST_CLR_KEEPS_SPIN: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_CLR && latch_q && !no_hold) |=> (!latch_q && motor_on)) else $error("clear gap"); // R2

    AST_STOP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(motor_on) |-> ($past(tick) || $past(no_hold))) else $error("stop without tick"); // R3

    AST_BYPASS_STOP: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_CLR && latch_q && no_hold) |=> !motor_on) else $error("bypass failed"); // R8

endmodule

// File: rtl/dm_mode_reg.sv
module dm_mode_reg
    import dm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [MODE_W-1:0] wdata,
    input  logic              motor_on,
    output dm_mode_t          mode_q
);
    logic accept;
    assign accept = wr && !motor_on;

    always_ff @(posedge clk) begin
        if (rst)         mode_q <= '0;
        else if (accept) mode_q <= mode_from_bits(wdata);
    end

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        motor_on |=> $stable(mode_q)) else $error("mode changed while spinning"); // R5

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && !motor_on) |=> (MODE_W'(mode_q) == $past(wdata))) else $error("mode not loaded"); // R6

endmodule

// File: rtl/dm_motor_ctl.sv
module dm_motor_ctl
    import dm_pkg::*;
#(
    parameter int HOLD_TICKS = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_set,
    input  logic              latch_clr,
    input  logic              tick,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic              motor_en,
    output logic              latch_live,
    output logic [MODE_W-1:0] mode_o,
    output logic              async_xfer
);
    dm_cmd_e  cmd;
    dm_mode_t mode_q;

    assign cmd = decode_cmd(latch_set, latch_clr);

    dm_spin_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .tick     (tick),
        .no_hold  (mode_q.no_hold),
        .latch_q  (latch_live),
        .motor_on (motor_en)
    );

    dm_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .wr       (mode_wr),
        .wdata    (mode_wdata),
        .motor_on (motor_en),
        .mode_q   (mode_q)
    );

    assign mode_o     = MODE_W'(mode_q);
    assign async_xfer = mode_q.async_xfer;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!motor_en && !latch_live && mode_o == '0)) else $error("reset state"); // R7

endmodule

// File: tb/dm_motor_ctl_test.sv
module dm_motor_ctl_test;
    localparam int HOLD = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       latch_set = 0, latch_clr = 0, tick = 0, mode_wr = 0;
    logic [3:0] mode_wdata = '0;
    logic       motor_en, latch_live, async_xfer;
    logic [3:0] mode_o;

    int checks = 0;
    int errors = 0;

    // behavioural reference
    int ref_latch = 0;
    int ref_left  = 0;
    int ref_mode  = 0;
    bit compare_on = 0;

    always #2.5 clk = ~clk;

    dm_motor_ctl #(.HOLD_TICKS(HOLD)) uut (
        .clk(clk), .rst(rst), .latch_set(latch_set), .latch_clr(latch_clr),
        .tick(tick), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .motor_en(motor_en), .latch_live(latch_live), .mode_o(mode_o),
        .async_xfer(async_xfer)
    );

    function automatic int ref_motor();
        return (ref_latch != 0 || ref_left > 0) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ref_latch = 0; ref_left = 0; ref_mode = 0;
        end else begin
            int was_on;
            int nohold;
            was_on = ref_motor();
            nohold = (ref_mode >> 1) & 1;
            if (latch_set) begin
                ref_latch = 1; ref_left = 0;
            end else if (latch_clr && ref_latch != 0) begin
                ref_latch = 0; ref_left = nohold ? 0 : HOLD;
            end else if (ref_left > 0 && tick) begin
                ref_left = ref_left - 1;
            end
            if (mode_wr && was_on == 0) ref_mode = int'(mode_wdata);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (compare_on && !rst) begin
            check(int'(latch_live) == ref_latch, "R1 latch_live", int'(latch_live), ref_latch);
            check(int'(motor_en) == ref_motor(), "R3 motor_en", int'(motor_en), ref_motor());
            check(int'(mode_o) == ref_mode, "R5 mode_o", int'(mode_o), ref_mode);
            check(int'(async_xfer) == (ref_mode & 1), "R9 async_xfer", int'(async_xfer), ref_mode & 1);
        end
    end

    task automatic step(input bit s, input bit c, input bit t, input bit w, input logic [3:0] d);
        @(negedge clk);
        latch_set = s; latch_clr = c; tick = t; mode_wr = w; mode_wdata = d;
    endtask

    task automatic idle(input int n, input bit t);
        for (int i = 0; i < n; i++) step(0, 0, t, 0, 4'h0);
    endtask

    initial begin : watchdog
        #(5 * 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R7 reset state
        check(motor_en == 0 && latch_live == 0 && mode_o == 0, "R7 reset", int'({motor_en, latch_live, mode_o}), 0);
        rst = 0;
        compare_on = 1;

        // R6 / R9: write while stopped
        step(0, 0, 0, 1, 4'b0101);
        step(0, 0, 0, 0, 4'h0);
        check(mode_o == 4'b0101, "R6 mode load", int'(mode_o), 5);
        check(async_xfer == 1'b1, "R9 async bit", int'(async_xfer), 1);

        // R1: set
        step(1, 0, 0, 0, 4'h0);
        step(0, 0, 0, 0, 4'h0);
        check(latch_live && motor_en, "R1 set", int'({latch_live, motor_en}), 3);

        // R5: write while running
        step(0, 0, 0, 1, 4'b1000);
        step(0, 0, 0, 0, 4'h0);
        check(mode_o == 4'b0101, "R5 locked running", int'(mode_o), 5);

        // R2: clear keeps motor on; tick in clear cycle not counted
        step(0, 1, 1, 0, 4'h0);
        step(0, 0, 0, 0, 4'h0);
        check(!latch_live && motor_en, "R2 clear hold", int'({latch_live, motor_en}), 1);
        step(0, 1, 1, 0, 4'h0);   // clear again while clear: only the tick counts
        step(0, 0, 1, 1, 4'b0000); // R5 write during hold
        step(0, 0, 0, 0, 4'h0);
        check(mode_o == 4'b0101, "R5 locked in hold", int'(mode_o), 5);
        idle(2, 1);                // 4 ticks counted so far
        check(motor_en == 1'b1, "R3 before last tick", int'(motor_en), 1);
        step(0, 0, 1, 0, 4'h0);    // 5th tick
        step(0, 0, 0, 0, 4'h0);
        check(motor_en == 1'b0, "R3 off after last tick", int'(motor_en), 0);

        // R4: set during hold
        step(1, 0, 0, 0, 4'h0);
        step(0, 1, 0, 0, 4'h0);
        idle(3, 1);
        step(1, 1, 1, 0, 4'h0);    // set wins over clear
        idle(HOLD + 3, 1);
        check(motor_en && latch_live, "R4 cancel hold", int'({latch_live, motor_en}), 3);
        step(0, 1, 0, 0, 4'h0);
        idle(HOLD + 2, 1);
        check(motor_en == 1'b0, "R3 stopped", int'(motor_en), 0);

        // R8: hold bypass
        step(0, 0, 0, 1, 4'b0010);
        step(1, 0, 0, 0, 4'h0);
        step(0, 1, 0, 0, 4'h0);
        step(0, 0, 0, 0, 4'h0);
        check(motor_en == 1'b0 && async_xfer == 1'b0, "R8 bypass", int'({motor_en, async_xfer}), 0);

        // mixed random stimulus checked against the model every cycle
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            step(r < 4, (r >= 4 && r < 10) || r == 0, $urandom_range(0, 2) == 0,
                 $urandom_range(0, 5) == 0, 4'($urandom_range(0, 15)));
        end
        idle(4 * HOLD, 1);

        compare_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule